// File: doc/BRIEF.md
# Single-Cycle Register Arithmetic Core

This block is a small processor core that completes one register-to-register arithmetic instruction on every clock. The program counter drives the address of an instruction memory that sits outside the block and answers combinationally. The returned 32-bit word is split into its fields. Two source registers are read from a 32-entry register file, and an ALU forms the sum, the difference and the bitwise OR side by side. A selector keeps the result that the function code asks for, and that result is written to the destination register at the next rising edge. The program counter then steps to the following word.

The write-back port (enable, index, value) is a plain output. It lets the surrounding logic, or a bench, follow every architectural update as it happens. Reset is asserted asynchronously, active low, and released through a two-stage synchronizer. While reset is held, each register is loaded with its own index number. This gives software seed values that it can combine into any other value using only the three supported operations.

Top module: `rtype_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr_o` is 0 and `wb_en_o` is 0, from the moment `rst_n` falls. After `rst_n` rises, the core stays in this state until the second rising clock edge. The first instruction executes in the cycle that follows that edge.
- R2: When running, `imem_addr_o` increases by exactly 4 on every clock, and its two low bits are always 00.
- R3: The instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6] and function [5:0]. The shift amount has no effect on the result.
- R4: Opcode 0 with function 0x21 writes R[rs] + R[rt] modulo 2^32 to R[rd].
- R5: Opcode 0 with function 0x23 writes R[rs] - R[rt] modulo 2^32 to R[rd].
- R6: Opcode 0 with function 0x25 writes R[rs] | R[rt] to R[rd].
- R7: Any other opcode or function code keeps `wb_en_o` at 0 and leaves every register unchanged. The PC still advances.
- R8: Register 0 always reads as 0. An instruction with rd = 0 keeps `wb_en_o` at 0.
- R9: Reset loads register i with the value i.
- R10: A value written by one instruction is the operand seen by the next instruction that reads that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Byte address of the current instruction |
| imem_data_i | input | 32 | Instruction word returned for `imem_addr_o` |
| wb_en_o | output | 1 | A register is written at the next rising edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_val_o | output | 32 | Value being written |

## Verification
A corrupted register value does not show up at once. It appears in `wb_val_o` the first time a later instruction reads that register, which can be many cycles later, so the bench model checks every write-back value against its own copy of all 32 registers. A PC fault shows on `imem_addr_o` in the very next cycle. A decode fault shows on `wb_en_o` or `wb_idx_o` within the same cycle as the faulty instruction. Random programs keep all registers in constant use, and directed cases cover wrap-around, register 0, back-to-back dependences and a reset applied in the middle of a run.

// File: rtl/rtype_pkg.sv
package rtype_pkg;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_OR
  } alu_sel_e;

  localparam logic [5:0] OPC_REG = 6'h00;
  localparam logic [5:0] FN_ADD  = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;

  typedef struct packed {
    logic [5:0] opc;
    logic [4:0] src_a;
    logic [4:0] src_b;
    logic [4:0] dst;
    logic [4:0] shamt;
    logic [5:0] fn;
  } rinstr_t;

endpackage

// File: rtl/rtype_rst_sync.sv
module rtype_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ok_n = stage_q[1];
endmodule

// File: rtl/rtype_pc.sv
module rtype_pc #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_ok_n,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q, pc_d;

  always_comb pc_d = pc_q + XLEN'(STEP);

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) pc_q <= '0;
    else           pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rst_ok_n |=> pc_q == $past(pc_q) + XLEN'(STEP));
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_ok_n)
    pc_q[1:0] == 2'b00);
endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_ok_n,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] rda_o,
  output logic [XLEN-1:0] rdb_o
);
  logic [XLEN-1:0] rf [NREG];

  assign rf[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic            hit;
    logic [XLEN-1:0] q;
    assign hit = we_i && (wa_i == AW'(r));
    always_ff @(posedge clk or negedge rst_ok_n) begin
      if (!rst_ok_n) q <= XLEN'(r);
      else if (hit)  q <= wd_i;
    end
    assign rf[r] = q;
  end

  assign rda_o = rf[ra_i];
  assign rdb_o = rf[rb_i];

  // R10: a write is seen by the next read of the same register
  a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ($past(we_i) && $past(wa_i) != '0 && ra_i == $past(wa_i)) |-> rda_o == $past(wd_i));
endmodule

// File: rtl/rtype_exec.sv
module rtype_exec
  import rtype_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [4:0]      ra_o,
  output logic [4:0]      rb_o,
  output logic [4:0]      rd_o,
  output logic            we_o,
  output logic [XLEN-1:0] res_o
);
  rinstr_t  f;
  alu_sel_e sel;
  logic     known;
  logic [XLEN-1:0] sum, diff, orv;
  logic     unused_shamt;

  assign f            = rinstr_t'(instr_i);
  assign unused_shamt = ^f.shamt;

  always_comb begin
    known = 1'b0;
    sel   = ALU_ADD;
    if (f.opc == OPC_REG) begin
      unique case (f.fn)
        FN_ADD:  begin known = 1'b1; sel = ALU_ADD; end
        FN_SUB:  begin known = 1'b1; sel = ALU_SUB; end
        FN_OR:   begin known = 1'b1; sel = ALU_OR;  end
        default: ;
      endcase
    end
  end

  always_comb begin
    sum  = opa_i + opb_i;
    diff = opa_i - opb_i;
    orv  = opa_i | opb_i;
    unique case (sel)
      ALU_SUB: res_o = diff;
      ALU_OR:  res_o = orv;
      default: res_o = sum;
    endcase
  end

  assign ra_o = f.src_a;
  assign rb_o = f.src_b;
  assign rd_o = f.dst;
  assign we_o = known && (f.dst != 5'd0);
endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import rtype_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_val_o
);
  localparam int NREG = 2 ** $bits(wb_idx_o);

  logic            rst_ok_n;
  logic [4:0]      ra, rb, rd;
  logic            dec_we;
  logic [XLEN-1:0] opa, opb, res;
  rinstr_t         ins;

  assign ins = rinstr_t'(imem_data_i);

  rtype_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n));

  rtype_pc #(.XLEN(XLEN), .STEP(STEP)) u_pc (
    .clk(clk), .rst_ok_n(rst_ok_n), .pc_o(imem_addr_o));

  rtype_exec #(.XLEN(XLEN)) u_exec (
    .instr_i(imem_data_i), .opa_i(opa), .opb_i(opb),
    .ra_o(ra), .rb_o(rb), .rd_o(rd), .we_o(dec_we), .res_o(res));

  assign wb_en_o  = dec_we && rst_ok_n;
  assign wb_idx_o = rd;
  assign wb_val_o = res;

  rtype_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_ok_n(rst_ok_n), .we_i(wb_en_o), .wa_i(rd), .wd_i(res),
    .ra_i(ra), .rb_i(rb), .rda_o(opa), .rdb_o(opb));

  a_r7_only_known_write: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wb_en_o |-> (ins.opc == OPC_REG &&
                 (ins.fn == FN_ADD || ins.fn == FN_SUB || ins.fn == FN_OR)));
  a_r8_no_write_r0: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wb_en_o |-> wb_idx_o != 5'd0);
  a_r4_add_wraps: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wb_en_o && ins.fn == FN_ADD) |-> wb_val_o == opa + opb);
  a_r5_sub_wraps: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wb_en_o && ins.fn == FN_SUB) |-> wb_val_o == opa - opb);
  a_r6_or_bits: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wb_en_o && ins.fn == FN_OR) |-> wb_val_o == (opa | opb));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_ok_n |-> !wb_en_o);
endmodule

// File: tb/tb_rtype_core.sv
module tb_rtype_core;
  localparam int CLK_HALF = 10;
  localparam logic [5:0] F_ADD = 6'h21, F_SUB = 6'h23, F_OR = 6'h25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_data;
  logic [31:0] pc;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [32];
  logic [31:0] exp_pc;

  always #CLK_HALF clk = ~clk;

  rtype_core dut (.clk(clk), .rst_n(rst_n), .imem_addr_o(pc), .imem_data_i(imem_data),
                  .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_val_o(wb_val));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {op, rs, rt, rd, sh, fn};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mdl[i] = 32'(i);
    exp_pc = 32'd0;
  endtask

  task automatic exec(input logic [31:0] ins, input string tag);
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    logic [31:0] a, b, res;
    bit          sup, en;
    string       t;
    imem_data = ins;
    #2;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a = mdl[rs]; b = mdl[rt];
    sup = (op == 6'd0) && (fn == F_ADD || fn == F_SUB || fn == F_OR);
    en  = sup && (rd != 5'd0);
    res = (fn == F_SUB) ? a - b : (fn == F_OR) ? (a | b) : a + b;
    t = (tag != "") ? tag : (!sup ? "R7" : (rd == 0) ? "R8" :
        (fn == F_ADD) ? "R4" : (fn == F_SUB) ? "R5" : "R6");
    chk(pc == exp_pc, "R2 pc step", pc, exp_pc);
    chk(pc[1:0] == 2'b00, "R2 pc align", {30'd0, pc[1:0]}, 32'd0);
    chk(wb_en == en, {t, " write enable"}, {31'd0, wb_en}, {31'd0, en});
    if (en) begin
      chk(wb_idx == rd, {t, " dest index"}, {27'd0, wb_idx}, {27'd0, rd});
      chk(wb_val == res, {t, " value"}, wb_val, res);
      mdl[rd] = res;
    end
    exp_pc = exp_pc + 32'd4;
    @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pc == 32'd0 && wb_en == 1'b0, "R1 sync window", pc, 32'd0);
    @(posedge clk);
    @(negedge clk);
    model_reset();
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      int r;
      logic [5:0] op, fn;
      r  = int'($urandom % 10);
      op = (r == 0) ? 6'(1 + $urandom % 63) : 6'd0;
      case ($urandom % 3)
        0: fn = F_ADD;
        1: fn = F_SUB;
        default: fn = F_OR;
      endcase
      if (r == 1) fn = 6'($urandom);
      exec(mk(op, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), fn), "");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    imem_data = mk(6'd0, 5'd1, 5'd1, 5'd1, 5'd0, F_ADD);
    repeat (3) @(negedge clk);
    #2;
    chk(pc == 32'd0, "R1 reset pc", pc, 32'd0);
    chk(wb_en == 1'b0, "R1 reset wb_en", {31'd0, wb_en}, 32'd0);
    release_reset();

    // R9: every register starts at its own index (read back by OR with r0 into itself)
    for (int i = 1; i < 32; i++) exec(mk(6'd0, 5'(i), 5'd0, 5'(i), 5'd0, F_OR), "R9");
    // R8: rd = 0 suppresses the write; r0 reads as 0
    exec(mk(6'd0, 5'd3, 5'd5, 5'd0, 5'd0, F_ADD), "R8");
    exec(mk(6'd0, 5'd0, 5'd0, 5'd7, 5'd0, F_OR), "R8");
    // R5 / R4 wrap-around
    exec(mk(6'd0, 5'd0, 5'd1, 5'd3, 5'd0, F_SUB), "R5");
    exec(mk(6'd0, 5'd3, 5'd3, 5'd4, 5'd0, F_ADD), "R4");
    exec(mk(6'd0, 5'd3, 5'd2, 5'd5, 5'd0, F_ADD), "R4");
    // R10: back-to-back dependence
    exec(mk(6'd0, 5'd4, 5'd4, 5'd6, 5'd0, F_ADD), "R10");
    exec(mk(6'd0, 5'd6, 5'd2, 5'd8, 5'd0, F_OR), "R10");
    // R3: extreme field values and a nonzero shift amount
    exec(mk(6'd0, 5'd30, 5'd29, 5'd31, 5'd31, F_ADD), "R3");
    exec(mk(6'd0, 5'd31, 5'd31, 5'd30, 5'd17, F_OR), "R3");
    // R7: unsupported codes leave r12 untouched
    exec(mk(6'h23, 5'd1, 5'd2, 5'd12, 5'd0, F_ADD), "R7");
    exec(mk(6'd0, 5'd1, 5'd2, 5'd12, 5'd0, 6'h20), "R7");
    exec(mk(6'd0, 5'd12, 5'd0, 5'd13, 5'd0, F_OR), "R7");

    random_run(3000);

    // R1: reset applied mid-run acts at once
    rst_n = 1'b0;
    #2;
    chk(pc == 32'd0, "R1 async pc", pc, 32'd0);
    chk(wb_en == 1'b0, "R1 async wb_en", {31'd0, wb_en}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    release_reset();
    exec(mk(6'd0, 5'd20, 5'd0, 5'd20, 5'd0, F_OR), "R9");
    random_run(1000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule